// File: doc/BRIEF.md
# Neuron Processing Engine

This block evaluates a sigmoid multilayer-perceptron neuron at a time. A shared bus delivers input activations in signed Q8.8 form. Each one is queued in a small local FIFO and then multiplied by the next weight from a circular weight store. The products are summed in a saturating 32-bit accumulator. When a neuron's last input has been consumed, the accumulator value is mapped to an index into a 256-entry sigmoid table. The table entry goes back toward the bus as the neuron result.

The engine holds no addresses. The global schedule must deliver inputs in exactly the order their weights were loaded. Several neurons share the engine in sequence. The weight read position simply continues through the store and wraps back to the first weight, so repeated network evaluations reuse the loaded weights without reloading them.

Configuration is done while the engine is idle. A restart pulse sets the fan-in (inputs per neuron) and empties the weight store. Weights are then written one per cycle.

Top module: `neuron_engine`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A `cfg_begin` pulse stores `cfg_fan_in`, empties the weight store and sets the weight read position to the first weight. Each `wt_we` cycle then appends `wt_data` at the next position. Writes beyond `WBUF_DEPTH` stored weights are ignored.
- R3: Inputs are consumed in arrival order. Each input is multiplied, as signed Q8.8, by the weight at the current read position, and the read position then advances by one. The product, in Q16.16, is added to the accumulator.
- R4: After `cfg_fan_in` inputs, the neuron result is issued, the accumulator returns to zero, and the next neuron starts from zero.
- R5: After the last stored weight the read position wraps to the first weight. This holds also in the middle of a neuron.
- R6: Every accumulation saturates at the signed 32-bit limits, 0x7FFFFFFF and 0x80000000, and does not wrap.
- R7: The table index comes from the final sum S (Q16.16). It is 255 when S >= 8.0 and 0 when S < -8.0. Otherwise it is floor(S/4096)+128, which gives steps of 1/16.
- R8: The table entry for index k, with d = k-128, is 128+4d when |d| <= 16. It is 192+(d-16) when d > 16, and 64+(d+16) when d < -16, clamped to the range 0..255. `out_data` is that entry in the low 8 bits with the upper 8 bits zero, that is, unsigned Q8.8 below 1.0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R10: `in_ready` is 0 exactly when the input FIFO holds `FIFO_DEPTH` entries. An input is taken only on a cycle with `in_valid` and `in_ready` both 1. While a result waits unaccepted, no input is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_begin | input | 1 | Restart configuration: load fan-in, empty weight store |
| cfg_fan_in | input | FANIN_W | Inputs per neuron |
| wt_we | input | 1 | Append one weight |
| wt_data | input | 16 | Weight, signed Q8.8 |
| in_valid | input | 1 | Bus input present |
| in_data | input | 16 | Input activation, signed Q8.8 |
| in_ready | output | 1 | FIFO has room |
| out_valid | output | 1 | Neuron result present |
| out_data | output | 16 | Neuron result, Q8.8 |
| out_ready | input | 1 | Result accepted |

## Verification
The bench uses `FIFO_DEPTH` = 4 and `WBUF_DEPTH` = 16. With a shallow FIFO, a stalled result backs the queue up to a full FIFO in a handful of cycles, which makes `in_ready` falling easy to reach. With a 16-entry weight store, random weight counts that do not divide the fan-in cause wraps in the middle of a neuron, and loading more weights than the store holds hits the ignored-write case. Full-scale operands cause both positive and negative accumulator saturation within four products.

// File: rtl/neuron_pkg.sv
package neuron_pkg;

  localparam int DATA_W    = 16;
  localparam int FRAC_W    = 8;
  localparam int ACC_W     = 2 * DATA_W;
  localparam int LUT_AW    = 8;
  localparam int LUT_DW    = 8;
  localparam int IDX_FRAC  = 4;
  localparam int IDX_SHIFT = 2 * FRAC_W - IDX_FRAC;
  localparam int LUT_MID   = 2 ** (LUT_AW - 1);
  localparam int CLAMP_MAG = LUT_MID << IDX_SHIFT;

  typedef logic signed [DATA_W-1:0] q_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic [LUT_AW-1:0]        lidx_t;

  // Saturating signed addition at the accumulator width.
  function automatic acc_t sat_add(input acc_t a, input acc_t b);
    logic [ACC_W:0] s;
    s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
    if (s[ACC_W] != s[ACC_W-1]) begin
      if (s[ACC_W]) return {1'b1, {(ACC_W-1){1'b0}}};
      else          return {1'b0, {(ACC_W-1){1'b1}}};
    end
    return acc_t'(s[ACC_W-1:0]);
  endfunction

  // Map a Q16.16 sum onto the activation table index.
  function automatic lidx_t sig_index(input acc_t s);
    acc_t t;
    if (s >= acc_t'(CLAMP_MAG))  return '1;
    if (s < -acc_t'(CLAMP_MAG))  return '0;
    t = s >>> IDX_SHIFT;
    return lidx_t'(t) + lidx_t'(LUT_MID);
  endfunction

endpackage

// File: rtl/ne_in_fifo.sv
module ne_in_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    if (pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    if (push && !pop)      lvl_d = lvl_q + LW'(1);
    else if (pop && !push) lvl_d = lvl_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign empty = (lvl_q == '0);
  assign full  = (lvl_q == LW'(DEPTH));
  assign level = lvl_q;
endmodule

// File: rtl/ne_weight_ring.sv
module ne_weight_ring #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic                       we,
  input  logic [W-1:0]               wdata,
  input  logic                       advance,
  output logic [W-1:0]               weight,
  output logic [$clog2(DEPTH)-1:0]   rd_ptr,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          room, wr_en, at_end;

  assign room   = (cnt_q < CW'(DEPTH));
  assign wr_en  = we && room && !restart;
  assign at_end = (CW'(rd_q) + CW'(1) == cnt_q);

  always_comb begin
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (restart) begin
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (wr_en)   cnt_d = cnt_q + CW'(1);
      if (advance) rd_d  = at_end ? '0 : rd_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[cnt_q[AW-1:0]] <= wdata;
  end

  assign weight = mem[rd_q];
  assign rd_ptr = rd_q;
  assign count  = cnt_q;
endmodule

// File: rtl/ne_sigmoid_lut.sv
module ne_sigmoid_lut #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic [AW-1:0] idx,
  output logic [DW-1:0] y
);
  localparam int N     = 2 ** AW;
  localparam int MID   = N / 2;
  localparam int KNEE  = 16;
  localparam int SLOPE = 4;
  localparam int TOP   = 2 ** DW - 1;

  function automatic logic [DW-1:0] entry(input int k);
    int d, v;
    d = k - MID;
    if (d >= -KNEE && d <= KNEE) v = MID + SLOPE * d;
    else if (d > KNEE)           v = MID + SLOPE * KNEE + (d - KNEE);
    else                         v = MID - SLOPE * KNEE + (d + KNEE);
    if (v < 0)   v = 0;
    if (v > TOP) v = TOP;
    return DW'(v);
  endfunction

  logic [DW-1:0] rom [N];

  for (genvar k = 0; k < N; k++) begin : g_rom
    assign rom[k] = entry(k);
  end

  assign y = rom[idx];
endmodule

// File: rtl/neuron_engine.sv
module neuron_engine
  import neuron_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int WBUF_DEPTH = 16,
  parameter int FANIN_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_begin,
  input  logic [FANIN_W-1:0] cfg_fan_in,
  input  logic               wt_we,
  input  logic [DATA_W-1:0]  wt_data,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  output logic               in_ready,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam int RP_W  = $clog2(WBUF_DEPTH);
  localparam int WC_W  = $clog2(WBUF_DEPTH + 1);

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_n_i <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_n_i <= rst_s1;
    end
  end

  logic [DATA_W-1:0] x_raw, w_raw;
  logic              f_empty, f_full, push, pop;
  logic [LVL_W-1:0]  fifo_level;
  logic [RP_W-1:0]   rd_ptr;
  logic [WC_W-1:0]   wcount;

  assign push     = in_valid && in_ready;
  assign in_ready = !f_full;

  ne_in_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n_i), .push(push), .din(in_data), .pop(pop),
    .dout(x_raw), .empty(f_empty), .full(f_full), .level(fifo_level)
  );

  ne_weight_ring #(.W(DATA_W), .DEPTH(WBUF_DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n_i), .restart(cfg_begin), .we(wt_we),
    .wdata(wt_data), .advance(pop), .weight(w_raw), .rd_ptr(rd_ptr),
    .count(wcount)
  );

  // multiply-accumulate datapath
  acc_t              acc_q, acc_d, prod, sum;
  lidx_t             lut_idx;
  logic [LUT_DW-1:0] lut_y;
  logic [FANIN_W-1:0] fan_q, fan_d, cnt_q, cnt_d;
  logic              ov_q, ov_d, last, can_run;
  logic [DATA_W-1:0] od_q, od_d;

  assign prod    = acc_t'(q_t'(x_raw)) * acc_t'(q_t'(w_raw));
  assign sum     = sat_add(acc_q, prod);
  assign lut_idx = sig_index(sum);
  assign last    = (cnt_q + FANIN_W'(1) == fan_q);
  assign can_run = !f_empty && (wcount != '0) && (fan_q != '0)
                   && (!ov_q || out_ready);
  assign pop     = can_run && !cfg_begin;

  ne_sigmoid_lut #(.AW(LUT_AW), .DW(LUT_DW)) u_lut (
    .idx(lut_idx), .y(lut_y)
  );

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    fan_d = fan_q;
    ov_d  = ov_q;
    od_d  = od_q;
    if (ov_q && out_ready) ov_d = 1'b0;
    if (cfg_begin) begin
      acc_d = '0;
      cnt_d = '0;
      fan_d = cfg_fan_in;
    end else if (pop) begin
      if (last) begin
        acc_d = '0;
        cnt_d = '0;
        ov_d  = 1'b1;
        od_d  = {{(DATA_W-LUT_DW){1'b0}}, lut_y};
      end else begin
        acc_d = sum;
        cnt_d = cnt_q + FANIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      acc_q <= '0;
      cnt_q <= '0;
      fan_q <= '0;
      ov_q  <= 1'b0;
      od_q  <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
      fan_q <= fan_d;
      ov_q  <= ov_d;
      od_q  <= od_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
endmodule

// File: rtl/neuron_engine_chk.sv
module neuron_engine_chk #(
  parameter int FIFO_DEPTH = 4,
  parameter int WBUF_DEPTH = 16,
  parameter int DATA_W     = 16,
  parameter int ACC_W      = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            out_valid,
  input logic                            out_ready,
  input logic [DATA_W-1:0]               out_data,
  input logic                            in_ready,
  input logic                            pop,
  input logic                            cfg_begin,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
  input logic [$clog2(WBUF_DEPTH)-1:0]   rd_ptr,
  input logic [$clog2(WBUF_DEPTH+1)-1:0] wcount,
  input logic signed [ACC_W-1:0]         acc_q
);
  localparam int RP_W = $clog2(WBUF_DEPTH);
  localparam int WC_W = $clog2(WBUF_DEPTH + 1);
  localparam int LV_W = $clog2(FIFO_DEPTH + 1);

  logic [WC_W-1:0] rd_next;
  assign rd_next = WC_W'(rd_ptr) + WC_W'(1);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[DATA_W-1:8] == '0)); // R8

  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (acc_q == '0)); // R4

  AST_RDPTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (wcount != '0) |-> (WC_W'(rd_ptr) < wcount)); // R5

  AST_RDPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !cfg_begin && (rd_next < wcount))
      |=> (rd_ptr == RP_W'($past(rd_ptr) + RP_W'(1)))); // R3

  AST_RDPTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !cfg_begin && (rd_next == wcount)) |=> (rd_ptr == '0)); // R5

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == LV_W'(FIFO_DEPTH)) |-> !in_ready); // R10

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level <= LV_W'(FIFO_DEPTH))); // R10

  AST_NO_POP_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !pop); // R10
endmodule

bind neuron_engine neuron_engine_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .WBUF_DEPTH(WBUF_DEPTH),
  .DATA_W(neuron_pkg::DATA_W), .ACC_W(neuron_pkg::ACC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .in_ready(in_ready), .pop(pop), .cfg_begin(cfg_begin),
  .fifo_level(fifo_level), .rd_ptr(rd_ptr), .wcount(wcount), .acc_q(acc_q)
);

// File: tb/neuron_engine_tb_top.sv
module neuron_engine_tb_top;
  localparam int FD = 4;
  localparam int WD = 16;
  localparam int FW = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_begin, wt_we, in_valid, out_ready;
  logic [FW-1:0] cfg_fan_in;
  logic [15:0] wt_data, in_data, out_data;
  logic        in_ready, out_valid;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  neuron_engine #(.FIFO_DEPTH(FD), .WBUF_DEPTH(WD), .FANIN_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_begin(cfg_begin), .cfg_fan_in(cfg_fan_in),
    .wt_we(wt_we), .wt_data(wt_data), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data)
  );

  // ---------------- reference model ----------------
  int          m_fan;
  int          m_nw;
  int          m_rd;
  int          m_cnt;
  longint      m_acc;
  logic [15:0] m_w [WD];
  logic [15:0] in_q [$];
  logic [15:0] exp_q [$];
  string       tag;

  function automatic longint sat32(input longint v);
    if (v > 64'sd2147483647)  return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic int index_of(input longint s);
    if (s >= 524288)  return 255;
    if (s < -524288)  return 0;
    return int'(s >>> 12) + 128;
  endfunction

  function automatic int table_val(input int k);
    int d, v;
    d = k - 128;
    if (d >= -16 && d <= 16) v = 128 + 4 * d;
    else if (d > 16)         v = 192 + (d - 16);
    else                     v = 64 + (d + 16);
    if (v < 0)   v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  function automatic void model_input(input logic [15:0] x);
    longint p;
    p = longint'($signed(x)) * longint'($signed(m_w[m_rd]));
    m_acc = sat32(m_acc + p);
    m_rd  = (m_rd + 1 == m_nw) ? 0 : m_rd + 1;
    m_cnt++;
    if (m_cnt == m_fan) begin
      exp_q.push_back(16'(table_val(index_of(m_acc))));
      m_acc = 0;
      m_cnt = 0;
    end
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic configure(input int fan, input logic [15:0] w [$]);
    @(negedge clk);
    cfg_begin  = 1'b1;
    cfg_fan_in = FW'(fan);
    @(negedge clk);
    cfg_begin = 1'b0;
    foreach (w[i]) begin
      wt_we   = 1'b1;
      wt_data = w[i];
      @(negedge clk);
    end
    wt_we = 1'b0;
    m_fan = fan;
    m_nw  = (w.size() > WD) ? WD : w.size();
    for (int i = 0; i < m_nw; i++) m_w[i] = w[i];
    m_rd  = 0;
    m_cnt = 0;
    m_acc = 0;
  endtask

  task automatic send(input logic [15:0] xs [$]);
    foreach (xs[i]) begin
      in_q.push_back(xs[i]);
      model_input(xs[i]);
    end
  endtask

  // Drive and observe at the falling edge; transfers happen at the next rise.
  task automatic run_stream(input bit rnd);
    bit          holding = 1'b0;
    logic [15:0] held = '0;
    int          guard = 0;
    while ((in_q.size() > 0 || exp_q.size() > 0 || out_valid) && guard < 20000) begin
      guard++;
      in_valid  = (in_q.size() > 0) && (!rnd || ($urandom % 4 != 0));
      in_data   = (in_q.size() > 0) ? in_q[0] : 16'h0;
      out_ready = !rnd || ($urandom % 3 != 0);
      #1;
      if (holding) begin
        check({tag, " R9 hold"}, {15'b0, out_valid, out_data}, {16'h0001, held});
      end
      holding = 1'b0;
      if (in_valid && in_ready) void'(in_q.pop_front());
      if (out_valid) begin
        if (out_ready) begin
          if (exp_q.size() == 0) check({tag, " extra output"}, 32'(out_data), 32'hFFFF_FFFF);
          else check(tag, 32'(out_data), 32'(exp_q.pop_front()));
        end else begin
          holding = 1'b1;
          held    = out_data;
        end
      end
      @(negedge clk);
    end
    in_valid  = 1'b0;
    out_ready = 1'b0;
    check({tag, " drained"}, 32'(exp_q.size()), 32'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] w [$];
    logic [15:0] xs [$];
    int          acc_cnt;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_begin = 1'b0; cfg_fan_in = '0; wt_we = 1'b0;
    wt_data = '0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 in_ready",  32'(in_ready),  32'd1);

    // R3/R2: weights 1.0, 0.5, -1.0 applied in load order
    tag = "R3 ordered mac";
    w = '{16'h0100, 16'h0080, 16'hFF00};
    configure(3, w);
    xs = '{16'h0100, 16'h0200, 16'h0080, 16'hFF80, 16'h0040, 16'h0300};
    send(xs);
    run_stream(1'b0);

    // R4: consecutive neurons start from a cleared accumulator
    tag = "R4 acc clear";
    w = '{16'h0200, 16'h0200};
    configure(2, w);
    xs = '{16'h0300, 16'h0300, 16'h0010, 16'h0000, 16'hFFF0, 16'h0000};
    send(xs);
    run_stream(1'b0);

    // R5: five weights, fan-in two: wraps inside a neuron
    tag = "R5 wrap";
    w = '{16'h0100, 16'h0040, 16'hFFC0, 16'h0080, 16'h0010};
    configure(2, w);
    for (int i = 0; i < 10; i++) xs[i] = 16'($urandom_range(0, 511) - 256);
    xs = xs[0:9];
    send(xs);
    run_stream(1'b1);

    // R6: positive and negative saturation (wrap would give index 64 / 160)
    tag = "R6 saturate";
    w = '{16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF};
    configure(4, w);
    xs = '{16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF,
           16'h8000, 16'h8000, 16'h8000, 16'h8000};
    send(xs);
    run_stream(1'b0);

    // R7/R8: index steps, floor for negatives, clamp edges
    tag = "R7 R8 index";
    w = '{16'h0100};
    configure(1, w);
    xs = '{16'h0000, 16'h0010, 16'hFFFF, 16'h0100, 16'hFF00, 16'h07FF,
           16'h0800, 16'hF800, 16'hF7FF, 16'h0110, 16'hFEF0};
    send(xs);
    run_stream(1'b0);

    // R10: stalled result lets the FIFO fill, then in_ready drops
    tag = "R10 fifo full";
    acc_cnt = 0;
    out_ready = 1'b0;
    for (int i = 0; i < FD + 3; i++) begin
      in_valid = 1'b1;
      in_data  = 16'(16 * (i + 1));
      #1;
      if (in_valid && in_ready) begin
        model_input(in_data);
        acc_cnt++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    #1;
    check("R10 accepted count", 32'(acc_cnt), 32'(FD + 1));
    check("R10 in_ready low", 32'(in_ready), 32'd0);
    check("R10 one result waiting", 32'(out_valid), 32'd1);
    @(negedge clk);
    run_stream(1'b0);

    // R2: writes past the store depth are ignored; random traffic
    for (int c = 0; c < 6; c++) begin
      int fan, nw;
      tag = "R2 random cfg";
      fan = $urandom_range(1, 6);
      nw  = (c == 0) ? WD + 3 : $urandom_range(1, WD);
      w.delete();
      for (int i = 0; i < nw; i++) w.push_back(16'($urandom_range(0, 511) - 256));
      configure(fan, w);
      xs.delete();
      for (int i = 0; i < fan * 8; i++) xs.push_back(16'($urandom_range(0, 2047) - 1024));
      send(xs);
      run_stream(1'b1);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule